// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Selectable Output Timing

This block is a first-in first-out buffer for 9-bit words. The writer and the reader each run on their own clock, and the two clocks need no fixed relation in frequency or phase. The depth is `2**ADDR_W` words. Each side computes its flags from its own pointer and a synchronized copy of the other side's pointer.

A static mode input picks the output timing. In standard timing, a word reaches the output register only when a read is issued, and the flags report empty and full. In fall-through timing, the oldest word is shown without a read, and the flags report output-ready and input-ready. In fall-through timing the output register adds one word of capacity.

The block also has these features:
- A half-full flag and two threshold flags.
- A parallel path that loads both thresholds.
- A master reset that restores the thresholds to one of two default pairs.
- A partial reset that empties the buffer but keeps the thresholds.
- A retransmit input that rewinds reading to the first word stored since the last reset.

Top module: `fifo9_dc`

## Requirements
- R1: A word on `din` is stored at a rising `wclk` edge when `wen` is 1 and the buffer is not full. A read advances at a rising `rclk` edge. Words leave in the order they were accepted, with their values unchanged.
- R2: When `fwft_en` is 0 (standard timing):
  - A stored word is not shown on `dout` until a read edge with `ren` high moves it there.
  - `dout` holds its value at every other edge.
  - `rd_flag` is 1 when no word is stored.
  - `wr_flag` is 1 when `2**ADDR_W` words are stored.
- R3: When `fwft_en` is 1 (fall-through timing):
  - The oldest word appears on `dout` with no read, and `rd_flag` goes to 1 while `dout` holds a valid word.
  - `wr_flag` is 1 while the memory has room.
  - Total capacity is `2**ADDR_W + 1` words.
- R4: A write while full, or a read while nothing is readable, changes no stored data, no pointer and no output.
- R5: `half_full` is 1 while the memory holds more than `2**ADDR_W / 2` words. In fall-through timing, a word held in the output register is not counted.
- R6: `almost_empty` is 1 while the readable word count, including a word held in the output register, is at most the empty threshold. `almost_full` is 1 while the free memory space is at most the full threshold.
- R7: While `rst_n` is 0 at both clocks, the buffer empties and `dout` becomes 0. Both thresholds are set to `DFLT_A` when `ofs_pick` is 0, or to `DFLT_B` when it is 1.
- R8: While `prst_n` is 0 at both clocks, the buffer empties and `dout` becomes 0. The thresholds keep their values.
- R9: When `ofs_load` is 1 at a `wclk` edge, `ofs_ae_in` becomes the empty threshold and `ofs_af_in` becomes the full threshold.
- R10: When `rtx` is 1 at an `rclk` edge, reading rewinds to the first word stored since the last reset (requires that no more than `2**ADDR_W` words were written since that reset). In standard timing, the next read returns that word. In fall-through timing, `rd_flag` is 0 after the `rtx` edge and is 1 with that word on `dout` one `rclk` edge later.
- R11: The flags never report data that is absent or space that is not free. After both sides have been idle for 4 cycles of each clock, every flag matches the true word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, active low, sampled by both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled by both clocks |
| fwft_en | input | 1 | Timing select: 0 standard, 1 fall-through; change only in master reset |
| ofs_pick | input | 1 | Default threshold pair applied at master reset |
| wen | input | 1 | Write request |
| din | input | 9 | Write data |
| ofs_load | input | 1 | Load both thresholds (write clock) |
| ofs_ae_in | input | ADDR_W | New empty threshold |
| ofs_af_in | input | ADDR_W | New full threshold |
| ren | input | 1 | Read request |
| rtx | input | 1 | Retransmit request (read clock) |
| dout | output | 9 | Read data register |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than half of the memory in use |
| almost_empty | output | 1 | Readable count at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
The main function is tried with four kinds of input pattern, and each one separates a different fault:
- A single word written into an empty buffer tells standard timing apart from fall-through timing.
- Step-by-step filling to capacity and beyond, with a flag check at every count, catches off-by-one errors in the full, half and threshold comparisons and exposes writes that are not blocked.
- Concurrent random writes and reads on the two unrelated clocks expose ordering loss, duplication and flag decisions taken on stale pointers.
- Threshold loads followed by partial and master resets distinguish what each reset clears. Retransmits after partial draining check where the read pointer lands.

// File: rtl/fifo9_pkg.sv
// Shared definitions for the dual-clock 9-bit FIFO.
// Assumes pointer widths of at most 32 bits.
package fifo9_pkg;

    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo9_ram.sv
// Storage array: one write port on the write clock, one asynchronous read port.
// Assumes the read side only addresses words whose write is already visible
// through the synchronized write pointer.
module fifo9_ram
    import fifo9_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo9_ptr_xfer.sv
// Moves a binary pointer into another clock domain: Gray-encoded in a source
// register, then passed through two destination flops and decoded.
// Assumes the source pointer changes by at most one per source clock, except
// across a retransmit, during which the writer is expected to be idle.
module fifo9_ptr_xfer
    import fifo9_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] gray_src;
    logic [W-1:0] gray_meta;
    logic [W-1:0] gray_sync;

    // Register the Gray form in the source domain so no logic glitch crosses.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            gray_src <= '0;
        end else begin
            gray_src <= W'(to_gray(32'(src_bin)));
        end
    end

    // Two-flop synchronizer in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            gray_meta <= '0;
            gray_sync <= '0;
        end else begin
            gray_meta <= gray_src;
            gray_sync <= gray_meta;
        end
    end

    assign dst_bin = W'(from_gray(32'(gray_sync)));

endmodule

// File: rtl/fifo9_wr_ctrl.sv
// Write-side control: write pointer, full and input-ready, half-full,
// almost-full, and the two threshold registers.
// Assumes rptr_sync is the read pointer already synchronized into wclk.
// The empty threshold is handed to the read side as a quasi-static value,
// so it is loaded only while the read side is idle.
module fifo9_wr_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DFLT_A = 7,
    parameter int DFLT_B = 63
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              fwft_en,
    input  logic              ofs_pick,
    input  logic              wen,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] ofs_ae_in,
    input  logic [ADDR_W-1:0] ofs_af_in,
    input  logic [ADDR_W:0]   rptr_sync,
    output logic [ADDR_W:0]   wptr,
    output logic              mem_we,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_full,
    output logic [ADDR_W-1:0] ae_ofs
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wcount;
    logic              full;
    logic [ADDR_W-1:0] af_ofs;

    assign wcount = wptr - rptr_sync;
    assign full   = (wcount == PTR_W'(DEPTH));
    assign mem_we = wen && !full;

    // Advance the write pointer on each accepted write; both resets clear it.
    always_ff @(posedge wclk) begin
        if (!rst_n || !prst_n) begin
            wptr <= '0;
        end else if (mem_we) begin
            wptr <= wptr + PTR_W'(1);
        end
    end

    // Threshold registers: defaults on master reset only, parallel load otherwise.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_ofs <= ofs_pick ? ADDR_W'(DFLT_B) : ADDR_W'(DFLT_A);
            af_ofs <= ofs_pick ? ADDR_W'(DFLT_B) : ADDR_W'(DFLT_A);
        end else if (ofs_load) begin
            ae_ofs <= ofs_ae_in;
            af_ofs <= ofs_af_in;
        end
    end

    assign wr_flag     = fwft_en ? !full : full;
    assign half_full   = (wcount > PTR_W'(DEPTH / 2));
    assign almost_full = (wcount >= (PTR_W'(DEPTH) - PTR_W'(af_ofs)));

    // R4
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n || !prst_n)
        (full && wen) |=> $stable(wptr));

    // R1
    wr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n || !prst_n)
        (wen && !full) |=> (wptr == $past(wptr) + PTR_W'(1)));

    // R11
    wcount_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n || !prst_n)
        wcount <= PTR_W'(DEPTH));

    // R8
    ofs_keep_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !ofs_load |=> ($stable(ae_ofs) && $stable(af_ofs)));

endmodule

// File: rtl/fifo9_rd_ctrl.sv
// Read-side control: read pointer, output register, empty or output-ready,
// almost-empty and retransmit.
// In standard timing the register loads only on a read. In fall-through
// timing it prefetches the oldest word and marks it valid.
// Assumes wptr_sync is the write pointer already synchronized into rclk.
module fifo9_rd_ctrl
    import fifo9_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              fwft_en,
    input  logic              ren,
    input  logic              rtx,
    input  logic [ADDR_W:0]   wptr_sync,
    input  word_t             rdata,
    input  logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rptr,
    output word_t             dout,
    output logic              rd_flag,
    output logic              almost_empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] rcount;
    logic [PTR_W-1:0] avail;
    logic             mem_empty;
    logic             out_vld;
    logic             rd_std;
    logic             load_fw;
    logic             advance;

    assign rcount    = wptr_sync - rptr;
    assign mem_empty = (rcount == '0);
    assign rd_std    = !fwft_en && ren && !mem_empty;
    assign load_fw   = fwft_en && !mem_empty && (!out_vld || ren);
    assign advance   = rd_std || load_fw;
    assign raddr     = rptr[ADDR_W-1:0];

    // Read pointer: cleared by either reset, rewound by retransmit, else advances.
    always_ff @(posedge rclk) begin
        if (!rst_n || !prst_n || rtx) begin
            rptr <= '0;
        end else if (advance) begin
            rptr <= rptr + PTR_W'(1);
        end
    end

    // Output word register, loaded whenever a word leaves the memory.
    always_ff @(posedge rclk) begin
        if (!rst_n || !prst_n) begin
            dout <= '0;
        end else if (advance && !rtx) begin
            dout <= rdata;
        end
    end

    // Valid mark of the output register in fall-through timing.
    always_ff @(posedge rclk) begin
        if (!rst_n || !prst_n || rtx || !fwft_en) begin
            out_vld <= 1'b0;
        end else if (load_fw) begin
            out_vld <= 1'b1;
        end else if (ren) begin
            out_vld <= 1'b0;
        end
    end

    assign avail        = rcount + PTR_W'(out_vld);
    assign almost_empty = (avail <= PTR_W'(ae_ofs));
    assign rd_flag      = fwft_en ? out_vld : mem_empty;

    // R4
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n || !prst_n)
        (!fwft_en && ren && mem_empty && !rtx) |=> ($stable(rptr) && $stable(dout)));

    // R2
    std_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n || !prst_n)
        (!fwft_en && !(ren && !mem_empty)) |=> $stable(dout));

    // R3
    fwft_fill_chk: assert property (@(posedge rclk) disable iff (!rst_n || !prst_n)
        (fwft_en && !out_vld && !mem_empty && !rtx) |=> out_vld);

    // R10
    rtx_rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n || !prst_n)
        rtx |=> ((rptr == '0) && !out_vld));

    // R11
    rcount_bound_chk: assert property (@(posedge rclk) disable iff (!rst_n || !prst_n)
        rcount <= PTR_W'(DEPTH));

endmodule

// File: rtl/fifo9_dc.sv
// Top of the dual-clock 9-bit FIFO. It ties the storage array, the two pointer
// crossings and the write-side and read-side controllers together.
// Assumes rst_n and prst_n are held low for several cycles of the slower
// clock, and that fwft_en changes only while rst_n is low.
module fifo9_dc
    import fifo9_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DFLT_A = 7,
    parameter int DFLT_B = 63
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              fwft_en,
    input  logic              ofs_pick,
    input  logic              wen,
    input  logic [8:0]        din,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] ofs_ae_in,
    input  logic [ADDR_W-1:0] ofs_af_in,
    input  logic              ren,
    input  logic              rtx,
    output logic [8:0]        dout,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int PTR_W = ADDR_W + 1;

    logic              clr_n;
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [PTR_W-1:0]  wptr_sync;
    logic [PTR_W-1:0]  rptr_sync;
    logic              mem_we;
    logic [ADDR_W-1:0] raddr;
    logic [ADDR_W-1:0] ae_ofs;
    word_t             rdata;

    assign clr_n = rst_n && prst_n;

    fifo9_ram #(.ADDR_W(ADDR_W)) u_ram (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    fifo9_ptr_xfer #(.W(PTR_W)) u_w2r (
        .src_clk   (wclk),
        .src_rst_n (clr_n),
        .src_bin   (wptr),
        .dst_clk   (rclk),
        .dst_rst_n (clr_n),
        .dst_bin   (wptr_sync)
    );

    fifo9_ptr_xfer #(.W(PTR_W)) u_r2w (
        .src_clk   (rclk),
        .src_rst_n (clr_n),
        .src_bin   (rptr),
        .dst_clk   (wclk),
        .dst_rst_n (clr_n),
        .dst_bin   (rptr_sync)
    );

    fifo9_wr_ctrl #(.ADDR_W(ADDR_W), .DFLT_A(DFLT_A), .DFLT_B(DFLT_B)) u_wr (
        .wclk        (wclk),
        .rst_n       (rst_n),
        .prst_n      (prst_n),
        .fwft_en     (fwft_en),
        .ofs_pick    (ofs_pick),
        .wen         (wen),
        .ofs_load    (ofs_load),
        .ofs_ae_in   (ofs_ae_in),
        .ofs_af_in   (ofs_af_in),
        .rptr_sync   (rptr_sync),
        .wptr        (wptr),
        .mem_we      (mem_we),
        .wr_flag     (wr_flag),
        .half_full   (half_full),
        .almost_full (almost_full),
        .ae_ofs      (ae_ofs)
    );

    fifo9_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .rclk         (rclk),
        .rst_n        (rst_n),
        .prst_n       (prst_n),
        .fwft_en      (fwft_en),
        .ren          (ren),
        .rtx          (rtx),
        .wptr_sync    (wptr_sync),
        .rdata        (rdata),
        .ae_ofs       (ae_ofs),
        .raddr        (raddr),
        .rptr         (rptr),
        .dout         (dout),
        .rd_flag      (rd_flag),
        .almost_empty (almost_empty)
    );

endmodule

// File: tb/test_fifo9_dc.sv
// Bench for fifo9_dc: directed corner cases plus seeded random traffic,
// checked against a queue model and flag functions computed from counts.
module test_fifo9_dc;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int DA    = 2;
    localparam int DB    = 5;

    logic          wclk = 0, rclk = 0;
    logic          rst_n = 0, prst_n = 1, fwft_en = 0, ofs_pick = 0;
    logic          wen = 0, ofs_load = 0, ren = 0, rtx = 0;
    logic [8:0]    din = '0;
    logic [AW-1:0] ofs_ae_in = '0, ofs_af_in = '0;
    logic [8:0]    dout;
    logic          rd_flag, wr_flag, half_full, almost_empty, almost_full;

    int         n_chk = 0, n_fail = 0;
    int         ae_o = DA, af_o = DA;
    logic [8:0] q[$];
    logic [8:0] hist[$];

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    fifo9_dc #(.ADDR_W(AW), .DFLT_A(DA), .DFLT_B(DB)) i_fifo9_dc (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n),
        .fwft_en(fwft_en), .ofs_pick(ofs_pick), .wen(wen), .din(din),
        .ofs_load(ofs_load), .ofs_ae_in(ofs_ae_in), .ofs_af_in(ofs_af_in),
        .ren(ren), .rtx(rtx), .dout(dout), .rd_flag(rd_flag),
        .wr_flag(wr_flag), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mem_words(input int n);
        if (fwft_en) return (n > 0) ? n - 1 : 0;
        return n;
    endfunction

    task automatic check_flags(input int n);
        int wc;
        bit erd, ewr;
        wc  = mem_words(n);
        erd = fwft_en ? (n > 0) : (n == 0);
        ewr = fwft_en ? (wc < DEPTH) : (wc == DEPTH);
        chk(rd_flag == erd, fwft_en ? "R3 rd_flag" : "R2 rd_flag", rd_flag, erd);
        chk(wr_flag == ewr, fwft_en ? "R3 wr_flag" : "R2 wr_flag", wr_flag, ewr);
        chk(half_full == (wc > DEPTH / 2), "R5 half_full", half_full, wc > DEPTH / 2);
        chk(almost_empty == (n <= ae_o), "R6 almost_empty", almost_empty, n <= ae_o);
        chk(almost_full == (wc >= DEPTH - af_o), "R6 almost_full", almost_full,
            wc >= DEPTH - af_o);
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic push_raw(input logic [8:0] d);
        @(negedge wclk);
        wen = 1; din = d;
        @(negedge wclk);
        wen = 0;
    endtask

    task automatic push(input logic [8:0] d);
        push_raw(d);
        q.push_back(d);
        hist.push_back(d);
    endtask

    task automatic pop_std(input string tag);
        logic [8:0] e;
        e = q.pop_front();
        @(negedge rclk); ren = 1;
        @(negedge rclk); ren = 0;
        chk(dout == e, tag, dout, e);
    endtask

    task automatic pop_fw(input string tag);
        logic [8:0] e;
        @(negedge rclk);
        e = q.pop_front();
        chk(rd_flag == 1'b1, "R3 ready before read", rd_flag, 1);
        chk(dout == e, tag, dout, e);
        ren = 1;
        @(negedge rclk); ren = 0;
    endtask

    task automatic hard_reset(input bit pick, input bit mode);
        @(negedge wclk);
        rst_n = 0; fwft_en = mode; ofs_pick = pick;
        repeat (6) @(negedge rclk);
        rst_n = 1;
        q.delete(); hist.delete();
        ae_o = pick ? DB : DA; af_o = ae_o;
        settle();
    endtask

    task automatic soft_reset();
        @(negedge wclk);
        prst_n = 0;
        repeat (6) @(negedge rclk);
        prst_n = 1;
        q.delete(); hist.delete();
        settle();
    endtask

    task automatic load_ofs(input int ae, input int af);
        @(negedge wclk);
        ofs_load = 1; ofs_ae_in = AW'(ae); ofs_af_in = AW'(af);
        @(negedge wclk);
        ofs_load = 0;
        ae_o = ae; af_o = af;
    endtask

    task automatic pulse_rtx();
        @(negedge rclk); rtx = 1;
        @(negedge rclk); rtx = 0;
    endtask

    task automatic random_run(input int n);
        bit wdone = 0;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    @(negedge wclk);
                    wen = 0;
                    if ($urandom % 2 == 1) begin
                        wen = 1;
                        din = 9'($urandom);
                        if (fwft_en ? wr_flag : !wr_flag) q.push_back(din);
                    end
                end
                @(negedge wclk); wen = 0;
                wdone = 1;
            end
            begin
                bit pend = 0, ign = 0;
                logic [8:0] pv = '0, old = '0;
                while (!(wdone && q.size() == 0 && !pend && !ign)) begin
                    @(negedge rclk);
                    if (pend) begin chk(dout == pv, "R1 order", dout, pv); pend = 0; end
                    if (ign) begin chk(dout == old, "R4 empty read", dout, old); ign = 0; end
                    ren = 0;
                    if ($urandom % 10 < 6) begin
                        if (!fwft_en) begin
                            ren = 1;
                            if (!rd_flag) begin pend = 1; pv = q.pop_front(); end
                            else begin ign = 1; old = dout; end
                        end else begin
                            ren = 1;
                            if (rd_flag) begin
                                chk(dout == q[0], "R1 order", dout, q[0]);
                                void'(q.pop_front());
                            end
                        end
                    end
                end
                @(negedge rclk); ren = 0;
            end
        join
    endtask

    initial begin : watchdog
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (6) @(negedge rclk);
        rst_n = 1;
        settle();

        // R7: reset state, standard timing, default pair A
        check_flags(0);
        chk(dout == 0, "R7 dout after reset", dout, 0);

        // R2: a stored word does not appear until read
        push(9'h1A5);
        settle();
        chk(rd_flag == 0, "R2 not empty", rd_flag, 0);
        chk(dout == 0, "R2 no fall-through", dout, 0);
        pop_std("R2 read returns word");
        settle();
        check_flags(0);

        // R1 R5 R6: fill step by step, then overflow attempt R4
        for (int i = 1; i <= DEPTH; i++) begin
            push(9'(i * 37));
            settle();
            check_flags(i);
        end
        push_raw(9'h0FF);
        settle();
        check_flags(DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_std("R1 fill order");
        settle();
        check_flags(0);
        // R4: read while empty leaves dout alone
        @(negedge rclk); ren = 1;
        @(negedge rclk); ren = 0;
        chk(dout == 9'(DEPTH * 37), "R4 empty read dout", dout, DEPTH * 37);

        // R9: parallel threshold load
        load_ofs(4, 3);
        for (int i = 1; i <= 13; i++) begin
            push(9'(i + 300));
            settle();
            check_flags(i);
        end
        chk(almost_full == 1, "R9 af threshold", almost_full, 1);

        // R8: partial reset keeps thresholds
        soft_reset();
        check_flags(0);
        chk(dout == 0, "R8 dout cleared", dout, 0);
        for (int i = 1; i <= 5; i++) begin
            push(9'(i + 100));
            settle();
            check_flags(i);
        end
        chk(almost_empty == 0, "R8 kept ae threshold", almost_empty, 0);

        // R10: retransmit in standard timing
        for (int i = 0; i < 3; i++) pop_std("R1 before rtx");
        pulse_rtx();
        q = hist;
        settle();
        check_flags(5);
        for (int i = 0; i < 5; i++) pop_std("R10 replay std");

        // R7: master reset with pick=1 gives pair B
        hard_reset(1, 0);
        chk(dout == 0, "R7 dout", dout, 0);
        for (int i = 0; i <= 6; i++) begin
            if (i > 0) begin push(9'(i)); settle(); end
            check_flags(i);
        end

        // R1 R4 R11: random traffic, standard timing
        soft_reset();
        random_run(400);
        settle();
        chk(rd_flag == 1, "R11 settled empty std", rd_flag, 1);
        check_flags(0);

        // R3: fall-through timing
        hard_reset(0, 1);
        check_flags(0);
        push(9'h155);
        settle();
        chk(dout == 9'h155, "R3 word shown without read", dout, 9'h155);
        check_flags(1);
        for (int i = 2; i <= DEPTH + 1; i++) begin
            push(9'(i * 11));
            settle();
            check_flags(i);
        end
        push_raw(9'h0AA);
        settle();
        check_flags(DEPTH + 1);
        for (int i = 0; i <= DEPTH; i++) pop_fw("R1 fwft order");
        settle();
        check_flags(0);

        // R10: retransmit in fall-through timing
        soft_reset();
        for (int i = 0; i < 4; i++) push(9'(i + 200));
        settle();
        pop_fw("R1 fwft pre-rtx");
        pop_fw("R1 fwft pre-rtx");
        pulse_rtx();
        chk(rd_flag == 0, "R10 ready drops", rd_flag, 0);
        @(negedge rclk);
        chk(rd_flag == 1, "R10 ready after one edge", rd_flag, 1);
        chk(dout == hist[0], "R10 first word again", dout, hist[0]);
        q = hist;
        settle();
        check_flags(4);
        for (int i = 0; i < 4; i++) pop_fw("R10 replay fwft");

        // R1 R11: random traffic, fall-through timing
        soft_reset();
        random_run(400);
        settle();
        chk(rd_flag == 0, "R11 settled empty fwft", rd_flag, 0);
        check_flags(0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule